// File: doc/BRIEF.md
# Privileged Control/Status Register Bank

This block is the software-visible register set of a memory-interface unit. It has one request port. Each request carries an 8-bit byte offset, a size code, a read/write flag, the privilege of the requester, a tag for its origin (system bus or CPU load/store), and a flag that marks a CPU access as buffered. An init-protection unlock level comes in beside the request. The bank holds five registers:

- a read-only identification word, with a revision parameter in its low byte;
- a main control word and a secondary control word, both driven out to the unit;
- two trap-flag words, one for synchronous CPU faults and one for asynchronous CPU faults. Hardware strobes can set any of their bits.

Every access is checked for shape (word size at an 8-byte-aligned offset), privilege, init protection and writes to read-only words. A violating access changes no register. If it came from the system bus, it is answered with a bus error. If it came from the CPU, it sets the error flag (bit 0) in the synchronous or asynchronous trap word and raises a one-cycle trap pulse. A supervisor read of a trap word returns the word and clears it. A user read only returns it.

A two-state machine sequences each request:
- ST_IDLE: the port is ready. A valid request is accepted, checked, and committed (write, clear, flag set) at the clock edge. The machine takes the transition *accept* to ST_RESP.
- ST_RESP: the response (data, bus error, trap pulse) is presented for one cycle. The machine takes the transition *retire* back to ST_IDLE.

Top module: `mi_priv_regbank`

## Requirements
- R1: After reset, the main control word is 0x00000070. The secondary control word and both trap words are zero. The identification word reads {0x0008C0, REVISION} with REVISION = 0x12 by default, and the port is ready.
- R2: Only accesses with size code 2'b10 (word) at an offset whose three low bits are zero are legal. Size codes 2'b00 (byte) and 2'b01 (half-word), and offsets not 8-byte aligned, are violations.
- R3: The identification word (offset 0x08) is readable at user or supervisor privilege. Any write to it is a violation.
- R4: Writes to the main control word (0x10) and the secondary control word (0x28) succeed only when the requester is supervisor (priv = 1) and unlock = 1. Otherwise they are violations and the word is unchanged.
- R5: A violation from the system bus (from_cpu = 0) gives bus error = 1 in the response, no trap pulse and no trap-flag change.
- R6: A violation from the CPU (from_cpu = 1) gives no bus error. It raises the trap pulse in the response cycle and sets bit 0 of the synchronous trap word (0x18) when buffered = 0, or of the asynchronous trap word (0x20) when buffered = 1.
- R7: A legal supervisor read of a trap word returns its contents and clears it. A legal user read returns the contents and leaves the word unchanged, with no error.
- R8: Legal word accesses to any other offset return zero data, ignore write data and report no error.
- R9: If a hardware set strobe arrives in the same cycle as a supervisor read-clear, the strobed bits are set after the clear, and the read returns the old contents.
- R10: A write to either trap word is a violation and leaves the word unchanged.
- R11: The response appears exactly one cycle after acceptance and lasts one cycle. The port is not ready during the response. Read data is zero on any violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request (ST_IDLE) |
| req_addr | input | ADDR_W | Byte offset within the bank |
| req_size | input | 2 | 00 byte, 01 half-word, 10 word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_super | input | 1 | 1 = supervisor privilege |
| req_from_cpu | input | 1 | 1 = CPU load/store, 0 = system bus |
| req_buffered | input | 1 | CPU access is buffered/asynchronous |
| prot_unlock | input | 1 | Init-protection unlock level |
| sync_set_i | input | DATA_W | Hardware set strobes for the synchronous trap word |
| async_set_i | input | DATA_W | Hardware set strobes for the asynchronous trap word |
| rsp_valid | output | 1 | Response cycle (ST_RESP) |
| rsp_rdata | output | DATA_W | Read data, zero for writes and violations |
| rsp_err | output | 1 | Bus error for a system-bus violation |
| trap_pulse | output | 1 | Trap request for a CPU violation |
| ctrl_q | output | DATA_W | Main control word |
| ctrl1_q | output | DATA_W | Secondary control word |

## Verification
The access check is exercised with each register offset combined with:
- both privilege levels;
- unlock set and clear;
- legal and illegal sizes;
- aligned, 4-aligned and odd offsets;
- system-bus, synchronous-CPU and buffered-CPU origins.

These combinations separate a bus error from a trap and show which trap word receives the flag. Repeated user and supervisor reads of a trap word show that only supervisor reads clear it. A strobe that coincides with a supervisor clear shows that the newly set bit survives. Read-back after every rejected write confirms that no register changed. Reserved offsets are probed for zero data with no error.

// File: rtl/mi_regbank_pkg.sv
package mi_regbank_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rb_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ID,
        SEL_CTRL,
        SEL_SFLAG,
        SEL_AFLAG,
        SEL_CTRL1
    } rb_sel_e;

    localparam logic [1:0] SIZE_WORD = 2'b10;
    localparam int OFF_ID    = 8'h08;
    localparam int OFF_CTRL  = 8'h10;
    localparam int OFF_SFLAG = 8'h18;
    localparam int OFF_AFLAG = 8'h20;
    localparam int OFF_CTRL1 = 8'h28;
    localparam int ALIGN_BITS = 3;

endpackage

// File: rtl/mi_access_check.sv
module mi_access_check
    import mi_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              write_i,
    input  logic              super_i,
    input  logic              unlock_i,
    output rb_sel_e           sel_o,
    output logic              viol_o
);

    logic shape_bad;
    logic ro_write;
    logic guard_fail;

    always_comb begin
        unique case (addr_i)
            ADDR_W'(OFF_ID):    sel_o = SEL_ID;
            ADDR_W'(OFF_CTRL):  sel_o = SEL_CTRL;
            ADDR_W'(OFF_SFLAG): sel_o = SEL_SFLAG;
            ADDR_W'(OFF_AFLAG): sel_o = SEL_AFLAG;
            ADDR_W'(OFF_CTRL1): sel_o = SEL_CTRL1;
            default:            sel_o = SEL_NONE;
        endcase
    end

    always_comb begin
        shape_bad  = (addr_i[ALIGN_BITS-1:0] != '0) || (size_i != SIZE_WORD);
        ro_write   = write_i && (sel_o == SEL_ID || sel_o == SEL_SFLAG || sel_o == SEL_AFLAG);
        guard_fail = write_i && (sel_o == SEL_CTRL || sel_o == SEL_CTRL1) && !(super_i && unlock_i);
        viol_o     = shape_bad || ro_write || guard_fail;
    end

endmodule

// File: rtl/mi_flag_reg.sv
module mi_flag_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] set_i,
    output logic [DATA_W-1:0] q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (clr_i || (set_i != '0)) begin
            q_o <= (clr_i ? '0 : q_o) | set_i;
        end
    end

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && (set_i == '0)) |=> $stable(q_o));

    // R9
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/mi_priv_regbank.sv
module mi_priv_regbank
    import mi_regbank_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 32,
    parameter logic [7:0]  REVISION   = 8'h12,
    parameter logic [31:0] CTRL_RESET = 32'h0000_0070
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_super,
    input  logic              req_from_cpu,
    input  logic              req_buffered,
    input  logic              prot_unlock,
    input  logic [DATA_W-1:0] sync_set_i,
    input  logic [DATA_W-1:0] async_set_i,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              trap_pulse,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] ctrl1_q
);

    localparam logic [DATA_W-1:0] ID_VALUE  = DATA_W'({24'h0008C0, REVISION});
    localparam logic [DATA_W-1:0] ERR_BIT   = DATA_W'(1);
    localparam logic [DATA_W-1:0] CTRL_INIT = DATA_W'(CTRL_RESET);

    rb_state_e state_q, state_d;
    rb_sel_e   sel;
    logic      viol;
    logic      accept;
    logic      legal_wr;
    logic      trap_sync, trap_async;
    logic      sclr, aclr;
    logic [DATA_W-1:0] sflag_q, aflag_q;
    logic [DATA_W-1:0] sflag_set, aflag_set;
    logic [DATA_W-1:0] rd_mux;

    mi_access_check #(.ADDR_W(ADDR_W)) u_check (
        .addr_i   (req_addr),
        .size_i   (req_size),
        .write_i  (req_write),
        .super_i  (req_super),
        .unlock_i (prot_unlock),
        .sel_o    (sel),
        .viol_o   (viol)
    );

    assign accept     = req_valid && (state_q == ST_IDLE);
    assign legal_wr   = accept && req_write && !viol;
    assign trap_sync  = accept && viol && req_from_cpu && !req_buffered;
    assign trap_async = accept && viol && req_from_cpu && req_buffered;
    assign sclr       = accept && !viol && !req_write && req_super && (sel == SEL_SFLAG);
    assign aclr       = accept && !viol && !req_write && req_super && (sel == SEL_AFLAG);
    assign sflag_set  = sync_set_i  | (trap_sync  ? ERR_BIT : '0);
    assign aflag_set  = async_set_i | (trap_async ? ERR_BIT : '0);

    mi_flag_reg #(.DATA_W(DATA_W)) u_sflag (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (sclr),
        .set_i (sflag_set),
        .q_o   (sflag_q)
    );

    mi_flag_reg #(.DATA_W(DATA_W)) u_aflag (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (aclr),
        .set_i (aflag_set),
        .q_o   (aflag_q)
    );

    // next-state logic: accept and retire transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (sel)
            SEL_ID:    rd_mux = ID_VALUE;
            SEL_CTRL:  rd_mux = ctrl_q;
            SEL_SFLAG: rd_mux = sflag_q;
            SEL_AFLAG: rd_mux = aflag_q;
            SEL_CTRL1: rd_mux = ctrl1_q;
            default:   rd_mux = '0;
        endcase
    end

    // control words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_INIT;
            ctrl1_q <= '0;
        end else if (legal_wr) begin
            if (sel == SEL_CTRL)  ctrl_q  <= req_wdata;
            if (sel == SEL_CTRL1) ctrl1_q <= req_wdata;
        end
    end

    // response outputs, captured on accept, shown in ST_RESP
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata  <= '0;
            rsp_err    <= 1'b0;
            trap_pulse <= 1'b0;
        end else begin
            rsp_rdata  <= (accept && !viol && !req_write) ? rd_mux : '0;
            rsp_err    <= accept && viol && !req_from_cpu;
            trap_pulse <= accept && viol && req_from_cpu;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);

    // R11
    resp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R5
    err_trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_err && trap_pulse));

    // R6
    trap_in_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_pulse || rsp_err) |-> rsp_valid);

    // R2
    bad_size_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_size != SIZE_WORD) |=> (rsp_err || trap_pulse));

    // R4
    ctrl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q != $past(ctrl_q)) |-> $past(req_valid && req_ready && req_write && req_super && prot_unlock));

endmodule

// File: tb/test_mi_priv_regbank.sv
module test_mi_priv_regbank;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        logic        trap;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_super = 1'b0;
    logic        req_from_cpu = 1'b0;
    logic        req_buffered = 1'b0;
    logic        prot_unlock = 1'b0;
    logic [31:0] sync_set_i = '0;
    logic [31:0] async_set_i = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        trap_pulse;
    logic [31:0] ctrl_q;
    logic [31:0] ctrl1_q;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    exp_t exp_q[$];

    logic [31:0] m_ctrl = 32'h70, m_ctrl1 = 0, m_sf = 0, m_af = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mi_priv_regbank i_mi_priv_regbank (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .req_super(req_super),
        .req_from_cpu(req_from_cpu), .req_buffered(req_buffered),
        .prot_unlock(prot_unlock),
        .sync_set_i(sync_set_i), .async_set_i(async_set_i),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .trap_pulse(trap_pulse), .ctrl_q(ctrl_q), .ctrl1_q(ctrl1_q)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: predicts the response from the requirements, pushes it, then drives
    task automatic acc(input string tag, input logic [7:0] a, input logic [1:0] sz,
                       input bit wr, input logic [31:0] wd, input bit sup, input bit cpu,
                       input bit buff, input bit unl,
                       input logic [31:0] hs = 0, input logic [31:0] ha = 0);
        exp_t e;
        bit bad, viol, is_ro, is_guard;
        logic [31:0] rd;
        bad      = (a[2:0] != 0) || (sz != 2'b10);
        is_ro    = (a == 8'h08) || (a == 8'h18) || (a == 8'h20);
        is_guard = (a == 8'h10) || (a == 8'h28);
        viol     = bad || (wr && is_ro) || (wr && is_guard && !(sup && unl));
        case (a)
            8'h08: rd = 32'h0008C012;
            8'h10: rd = m_ctrl;
            8'h18: rd = m_sf;
            8'h20: rd = m_af;
            8'h28: rd = m_ctrl1;
            default: rd = 0;
        endcase
        e.rdata = (viol || wr) ? 32'h0 : rd;
        e.err   = viol && !cpu;
        e.trap  = viol && cpu;
        e.tag   = tag;
        if (!viol && wr && a == 8'h10) m_ctrl = wd;
        if (!viol && wr && a == 8'h28) m_ctrl1 = wd;
        if (!viol && !wr && sup && a == 8'h18) m_sf = 0;
        if (!viol && !wr && sup && a == 8'h20) m_af = 0;
        m_sf = m_sf | hs | ((viol && cpu && !buff) ? 32'h1 : 32'h0);
        m_af = m_af | ha | ((viol && cpu && buff) ? 32'h1 : 32'h0);
        exp_q.push_back(e);
        @(negedge clk);
        req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        req_super = sup; req_from_cpu = cpu; req_buffered = buff; prot_unlock = unl;
        sync_set_i = hs; async_set_i = ha; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; sync_set_i = 0; async_set_i = 0;
        chk(!req_ready, {tag, " R11 ready low in response"}, 64'(req_ready), 64'd0);
        chk(ctrl_q == m_ctrl && ctrl1_q == m_ctrl1, {tag, " R4 control words"},
            {ctrl_q, ctrl1_q}, {m_ctrl, m_ctrl1});
    endtask

    // monitor: pops the expected item in the response cycle
    always @(negedge clk) begin
        if (rst_n && (trap_pulse || rsp_err) && !rsp_valid)
            chk(1'b0, "R11 error/trap outside response", {trap_pulse, rsp_err}, 64'd0);
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected response", 64'(rsp_valid), 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_rdata === e.rdata && rsp_err === e.err && trap_pulse === e.trap,
                    e.tag, {rsp_rdata, rsp_err, trap_pulse}, {e.rdata, e.err, e.trap});
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++; mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_q == 32'h70 && ctrl1_q == 0, "R1 control reset", {ctrl_q, ctrl1_q}, {32'h70, 32'h0});
        chk(req_ready && !rsp_valid, "R1 port idle after reset", {req_ready, rsp_valid}, 64'h2);

        // R1 R3: reset contents read at user level from the bus
        acc("R1 R3 read id user", 8'h08, 2'b10, 0, 0, 0, 0, 0, 0);
        acc("R1 read ctrl",       8'h10, 2'b10, 0, 0, 0, 0, 0, 0);
        acc("R1 read sflag",      8'h18, 2'b10, 0, 0, 0, 0, 0, 0);
        acc("R1 read aflag",      8'h20, 2'b10, 0, 0, 0, 0, 0, 0);
        acc("R1 read ctrl1",      8'h28, 2'b10, 0, 0, 0, 0, 0, 0);

        // R3 R5: write to id from bus gives bus error
        acc("R3 R5 write id bus", 8'h08, 2'b10, 1, 32'hFFFF, 1, 0, 0, 1);
        acc("R3 id unchanged",    8'h08, 2'b10, 0, 0, 1, 0, 0, 0);
        acc("R5 sflag untouched", 8'h18, 2'b10, 0, 0, 0, 0, 0, 0);

        // R6: CPU synchronous violation
        acc("R6 write id cpu sync", 8'h08, 2'b10, 1, 0, 1, 1, 0, 1);
        acc("R7 user read sflag",   8'h18, 2'b10, 0, 0, 0, 1, 0, 0);
        acc("R7 user read again",   8'h18, 2'b10, 0, 0, 0, 1, 0, 0);
        acc("R7 super read clears", 8'h18, 2'b10, 0, 0, 1, 1, 0, 0);
        acc("R7 after clear",       8'h18, 2'b10, 0, 0, 1, 0, 0, 0);

        // R4: control guard
        acc("R4 ctrl write ok",       8'h10, 2'b10, 1, 32'hA5A5_0001, 1, 0, 0, 1);
        acc("R4 ctrl readback",       8'h10, 2'b10, 0, 0, 0, 0, 0, 0);
        acc("R4 ctrl user write",     8'h10, 2'b10, 1, 32'h1234, 0, 0, 0, 1);
        acc("R4 R6 ctrl locked async",8'h10, 2'b10, 1, 32'h5678, 1, 1, 1, 0);
        acc("R6 aflag set",           8'h20, 2'b10, 0, 0, 0, 0, 0, 0);
        acc("R6 sflag not set",       8'h18, 2'b10, 0, 0, 0, 0, 0, 0);
        acc("R7 super read aflag",    8'h20, 2'b10, 0, 0, 1, 0, 0, 0);
        acc("R7 aflag cleared",       8'h20, 2'b10, 0, 0, 0, 0, 0, 0);
        acc("R4 ctrl1 write ok",      8'h28, 2'b10, 1, 32'hCAFE_F00D, 1, 1, 0, 1);
        acc("R4 ctrl1 user cpu",      8'h28, 2'b10, 1, 32'h0, 0, 1, 0, 1);
        acc("R4 ctrl1 readback",      8'h28, 2'b10, 0, 0, 0, 0, 0, 0);

        // R2: size and alignment
        acc("R2 byte ctrl1",        8'h28, 2'b00, 1, 32'h1, 1, 0, 0, 1);
        acc("R2 half read id",      8'h08, 2'b01, 0, 0, 1, 0, 0, 0);
        acc("R2 offset 0x0C",       8'h0C, 2'b10, 0, 0, 1, 0, 0, 0);
        acc("R2 offset 0x14 cpu",   8'h14, 2'b10, 1, 32'h9, 1, 1, 0, 1);
        acc("R2 odd offset cpu buf",8'h11, 2'b10, 0, 0, 1, 1, 1, 0);
        acc("R2 flags read",        8'h18, 2'b10, 0, 0, 1, 0, 0, 0);
        acc("R2 aflag read",        8'h20, 2'b10, 0, 0, 1, 0, 0, 0);

        // R8: reserved offsets
        acc("R8 read 0x00",  8'h00, 2'b10, 0, 0, 1, 0, 0, 0);
        acc("R8 read 0x30",  8'h30, 2'b10, 0, 0, 0, 1, 0, 0);
        acc("R8 write 0xF8", 8'hF8, 2'b10, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        acc("R8 read 0xF8",  8'hF8, 2'b10, 0, 0, 1, 0, 0, 0);

        // R10: trap words are read-only
        acc("R10 strobe during read", 8'h18, 2'b10, 0, 0, 0, 0, 0, 0, 32'h0000_00F0, 32'h0300_0000);
        acc("R10 write sflag bus",    8'h18, 2'b10, 1, 32'h0, 1, 0, 0, 1);
        acc("R10 write aflag bus",    8'h20, 2'b10, 1, 32'h0, 1, 0, 0, 1);
        acc("R10 sflag intact",       8'h18, 2'b10, 0, 0, 0, 0, 0, 0);
        acc("R10 aflag intact",       8'h20, 2'b10, 0, 0, 0, 0, 0, 0);

        // R9: strobe coincides with supervisor clear
        acc("R9 clear with strobe", 8'h18, 2'b10, 0, 0, 1, 0, 0, 0, 32'h0000_0100, 32'h0);
        acc("R9 strobed bit kept",  8'h18, 2'b10, 0, 0, 0, 0, 0, 0);
        acc("R9 aflag clear strobe",8'h20, 2'b10, 0, 0, 1, 0, 0, 0, 32'h0, 32'h8000_0000);
        acc("R9 aflag kept",        8'h20, 2'b10, 0, 0, 0, 0, 0, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all responses seen", 64'(exp_q.size()), 64'd0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule